// File: doc/BRIEF.md
# Scan-Stitched Register Bank with Debug Lock

This block holds a small functional datapath, a parallel-load data register and a free-running serial delay line, with every one of those flops stitched into one scan chain. When the scan-enable input is high, the chain shifts serially from the scan-in port to the scan-out port. When it is low, the flops run their normal logic, and the first clock after scan-enable falls captures functional data.

Inside the delay line only the head stage has a multiplexer that picks between functional data and the chain. The later stages always take the previous stage, so they need no multiplexer and still sit on the chain in order. A lock flop gates the debug-enable output. It is kept off the chain, and its clock enable is removed while scan-enable is high, so no shifting or capture can alter it. Software clears it by writing a fixed key value in functional mode, and can set it again with a relock write.

Top module: `scanlock_bank`

## Requirements
- R1: A synchronous active-high reset clears `data_q` and every delay-line stage to zero and sets the lock, so `debug_en`, `sr_tap` and `scan_out` read 0 on the clock after reset is sampled.
- R2: With `scan_en` low, a clock with `ld_en` high loads `data_in` into `data_q`. A clock with `ld_en` low leaves `data_q` unchanged.
- R3: With `scan_en` low, `sr_tap` equals the `sr_din` value sampled SR_DEPTH clocks earlier (default 4).
- R4: With `scan_en` high, the chain length is DATA_W+SR_DEPTH (default 12). A bit sampled on `scan_in` appears on `scan_out` after exactly that many shift clocks.
- R5: Chain order, from `scan_in` onward: `data_q` bit 0 up to bit DATA_W-1, then delay-line stage 0 up to its last stage, which drives `scan_out`. After each shift clock, `data_q[i]` holds what chain position i-1 held before it (`scan_in` for bit 0).
- R6: During scan shifting, `ld_en`, `data_in` and `sr_din` have no effect. After `scan_en` falls, the next clock captures functional data again.
- R7: `debug_en` is the inverse of the lock. A `unlock_wr` with `key_in` equal to 8'hA5 and `scan_en` low clears the lock on that clock.
- R8: A `unlock_wr` whose key differs from 8'hA5 leaves the lock unchanged.
- R9: While `scan_en` is high, `unlock_wr` and `relock_wr` are ignored, and the lock keeps its value through any number of shift clocks.
- R10: A `relock_wr` with `scan_en` low sets the lock and takes priority over a simultaneous valid unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | High: shift the chain; low: functional mode |
| scan_in | input | 1 | Serial chain input |
| scan_out | output | 1 | Serial chain output (last delay-line stage) |
| ld_en | input | 1 | Functional load enable for the data register |
| data_in | input | 8 | Functional load data |
| data_q | output | 8 | Data register contents |
| sr_din | input | 1 | Functional input of the delay line |
| sr_tap | output | 1 | Last delay-line stage |
| unlock_wr | input | 1 | Unlock request, qualified by the key |
| relock_wr | input | 1 | Relock request |
| key_in | input | 8 | Key presented with an unlock request |
| debug_en | output | 1 | High when the lock is cleared |

## Verification
A stage dropped from the chain, or two stages swapped, makes the chain shorter or out of order. A bit then reaches `scan_out` one or more clocks early, and `data_q` shows a reordered pattern on the first shift clock after the bits arrive. A lock flop that responds during scan makes `debug_en` change on the clock after an unlock write or relock write issued with scan high. A lock flop that sits on the chain makes `debug_en` follow the shifted data within one chain length. A stray multiplexer on a plain delay stage, or a missing one on the head, shows up as a corrupted `sr_tap` sequence SR_DEPTH clocks after the functional stimulus.

// File: rtl/scanlock_pkg.sv
package scanlock_pkg;

    parameter int DATA_W    = 8;
    parameter int SR_DEPTH  = 4;
    parameter int KEY_W     = 8;
    parameter logic [KEY_W-1:0] UNLOCK_KEY = 8'hA5;

    localparam int CHAIN_LEN = DATA_W + SR_DEPTH;

    typedef struct packed {
        logic             unlock;
        logic             relock;
        logic [KEY_W-1:0] key;
    } lock_cmd_t;

    typedef enum logic {
        MODE_FUNC = 1'b0,
        MODE_SHIFT = 1'b1
    } scan_mode_e;

    function automatic logic key_matches(input logic [KEY_W-1:0] k);
        return k == UNLOCK_KEY;
    endfunction

endpackage

// File: rtl/scan_data_reg.sv
module scan_data_reg
    import scanlock_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  scan_mode_e   mode,
    input  logic         chain_in,
    input  logic         ld_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] shift_src;

    generate
        if (W > 1) begin : g_wide
            assign shift_src = {q[W-2:0], chain_in};
        end else begin : g_narrow
            assign shift_src = chain_in;
        end
    endgenerate

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic nxt;
            always_comb begin
                if (mode == MODE_SHIFT)
                    nxt = shift_src[i];
                else
                    nxt = ld_en ? d[i] : q[i];
            end
            always_ff @(posedge clk) begin
                if (rst) q[i] <= 1'b0;
                else     q[i] <= nxt;
            end
        end
    endgenerate

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FUNC && !ld_en) |=> $stable(q));

    // R6
    load_ignored_in_scan_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SHIFT) |=> q[0] == $past(chain_in));

endmodule

// File: rtl/head_mux_shreg.sv
module head_mux_shreg
    import scanlock_pkg::*;
#(
    parameter int DEPTH = SR_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  scan_mode_e       mode,
    input  logic             chain_in,
    input  logic             func_in,
    output logic [DEPTH-1:0] q
);

    logic head_nxt;

    // Only the head stage chooses between functional data and the chain.
    assign head_nxt = (mode == MODE_SHIFT) ? chain_in : func_in;

    always_ff @(posedge clk) begin
        if (rst) q[0] <= 1'b0;
        else     q[0] <= head_nxt;
    end

    // Later stages: plain D from the previous stage, still on the chain.
    generate
        for (genvar k = 1; k < DEPTH; k++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) q[k] <= 1'b0;
                else     q[k] <= q[k-1];
            end
        end
    endgenerate

    // R3
    head_func_path_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FUNC) |=> q[0] == $past(func_in));

    // R4
    head_shift_path_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SHIFT) |=> q[0] == $past(chain_in));

endmodule

// File: rtl/lock_keeper.sv
module lock_keeper
    import scanlock_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  scan_mode_e mode,
    input  lock_cmd_t  cmd,
    output logic       locked
);

    logic clk_en;
    logic nxt;

    // Clock enable removed for the whole scan window: neither shift nor
    // capture reaches this flop, and it is not on the chain.
    assign clk_en = (mode == MODE_FUNC);

    always_comb begin
        nxt = locked;
        if (cmd.relock)
            nxt = 1'b1;
        else if (cmd.unlock && key_matches(cmd.key))
            nxt = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)         locked <= 1'b1;
        else if (clk_en) locked <= nxt;
    end

    // R1
    reset_locks_chk: assert property (@(posedge clk) rst |=> locked);

    // R9
    frozen_in_scan_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SHIFT) |=> $stable(locked));

    // R7
    unlock_needs_key_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(cmd.unlock && cmd.key == UNLOCK_KEY && mode == MODE_FUNC));

    // R10
    relock_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FUNC && cmd.relock) |=> locked);

endmodule

// File: rtl/scanlock_bank.sv
module scanlock_bank
    import scanlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_en,
    input  logic              scan_in,
    output logic              scan_out,
    input  logic              ld_en,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_q,
    input  logic              sr_din,
    output logic              sr_tap,
    input  logic              unlock_wr,
    input  logic              relock_wr,
    input  logic [KEY_W-1:0]  key_in,
    output logic              debug_en
);

    scan_mode_e          mode;
    logic [SR_DEPTH-1:0] sr_q;
    lock_cmd_t           cmd;
    logic                locked;

    assign mode = scan_en ? MODE_SHIFT : MODE_FUNC;
    assign cmd  = '{unlock: unlock_wr, relock: relock_wr, key: key_in};

    scan_data_reg #(.W(DATA_W)) u_data (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .chain_in (scan_in),
        .ld_en    (ld_en),
        .d        (data_in),
        .q        (data_q)
    );

    head_mux_shreg #(.DEPTH(SR_DEPTH)) u_sr (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .chain_in (data_q[DATA_W-1]),
        .func_in  (sr_din),
        .q        (sr_q)
    );

    lock_keeper u_lock (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .cmd    (cmd),
        .locked (locked)
    );

    assign scan_out = sr_q[SR_DEPTH-1];
    assign sr_tap   = sr_q[SR_DEPTH-1];
    assign debug_en = ~locked;

    // R5
    chain_link_chk: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> sr_q[0] == $past(data_q[DATA_W-1]));

    // R7
    debug_follows_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (!scan_en && unlock_wr && !relock_wr && key_in == UNLOCK_KEY) |=> debug_en);

endmodule

// File: tb/tb_scanlock_bank.sv
module tb_scanlock_bank;
    import scanlock_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              scan_en = 1'b0, scan_in = 1'b0, ld_en = 1'b0, sr_din = 1'b0;
    logic              unlock_wr = 1'b0, relock_wr = 1'b0;
    logic [DATA_W-1:0] data_in = '0;
    logic [KEY_W-1:0]  key_in = '0;
    logic              scan_out, sr_tap, debug_en;
    logic [DATA_W-1:0] data_q;

    always #4 clk = ~clk;  // 125 MHz

    scanlock_bank dut (.*);

    typedef struct {
        string             tag;
        logic [DATA_W-1:0] dq;
        logic              so;
        logic              dbg;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;

    // reference state, kept from the requirements
    logic [DATA_W-1:0]   m_data = '0;
    logic [SR_DEPTH-1:0] m_sr = '0;
    logic                m_lock = 1'b1;

    task automatic step(input string tag, input logic r, input logic se, input logic si,
                        input logic ld, input logic [DATA_W-1:0] din, input logic sd,
                        input logic unl, input logic rel, input logic [KEY_W-1:0] k);
        logic [CHAIN_LEN-1:0] c;
        exp_t e;
        @(negedge clk);
        rst = r; scan_en = se; scan_in = si; ld_en = ld; data_in = din;
        sr_din = sd; unlock_wr = unl; relock_wr = rel; key_in = k;
        if (r) begin
            m_data = '0; m_sr = '0; m_lock = 1'b1;
        end else if (se) begin
            c = {m_sr, m_data};
            c = {c[CHAIN_LEN-2:0], si};
            m_data = c[DATA_W-1:0];
            m_sr   = c[CHAIN_LEN-1:DATA_W];
        end else begin
            if (ld) m_data = din;
            m_sr = {m_sr[SR_DEPTH-2:0], sd};
            if (rel) m_lock = 1'b1;
            else if (unl && k == 8'hA5) m_lock = 1'b0;
        end
        e.tag = tag; e.dq = m_data; e.so = m_sr[SR_DEPTH-1]; e.dbg = ~m_lock;
        exp_q.push_back(e);
        @(posedge clk);
    endtask

    // monitor: pops one expected item per clock and compares
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (data_q !== e.dq || scan_out !== e.so || sr_tap !== e.so || debug_en !== e.dbg) begin
                n_bad++;
                $display("FAIL %s: data_q=%h so=%b tap=%b dbg=%b expected data_q=%h so=%b dbg=%b",
                         e.tag, data_q, scan_out, sr_tap, debug_en, e.dq, e.so, e.dbg);
            end
        end
    end

    task automatic direct(input string tag, input logic ok, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int cnt;
        logic seen;
        // R1 reset state
        step("R1", 1, 0, 0, 0, '0, 0, 0, 0, '0);
        step("R1", 1, 1, 1, 1, 8'hFF, 1, 1, 0, 8'hA5);
        // R2 loads and holds
        step("R2", 0, 0, 0, 1, 8'h3C, 0, 0, 0, '0);
        step("R2", 0, 0, 0, 0, 8'hFF, 0, 0, 0, '0);
        step("R2", 0, 0, 0, 1, 8'hC3, 0, 0, 0, '0);
        for (int i = 0; i < 6; i++)
            step("R2", 0, 0, 0, i[0], 8'($urandom), 0, 0, 0, '0);
        // R3 delay line
        for (int i = 0; i < 16; i++)
            step("R3", 0, 0, 0, 0, '0, 1'((32'h5A3 >> i) & 1), 0, 0, '0);
        // R8 wrong keys
        step("R8", 0, 0, 0, 0, '0, 0, 1, 0, 8'hA4);
        step("R8", 0, 0, 0, 0, '0, 0, 1, 0, 8'h5A);
        // R9 unlock during scan is ignored
        step("R9", 0, 1, 0, 0, '0, 0, 1, 0, 8'hA5);
        step("R9", 0, 1, 1, 1, 8'hFF, 1, 1, 0, 8'hA5);
        // R4 chain length: flush zeros, then one marker bit
        for (int i = 0; i < CHAIN_LEN; i++)
            step("R4", 0, 1, 0, 1, 8'hFF, 1, 0, 0, '0);
        step("R4", 0, 1, 1, 0, '0, 0, 0, 0, '0);
        cnt = 0; seen = 1'b0;
        for (int i = 0; i < CHAIN_LEN + 2; i++) begin
            #2;
            if (scan_out && !seen) begin seen = 1'b1; cnt = i; end
            step("R4", 0, 1, 0, 0, '0, 0, 0, 0, '0);
        end
        #2;
        // marker shifted on clock 1; seen after clock cnt+1
        direct("R4 chain length", seen && (cnt + 1) == CHAIN_LEN, cnt + 1, CHAIN_LEN);
        // R5/R6 ordering with a pattern, functional inputs toggling
        for (int i = 0; i < 2 * CHAIN_LEN; i++)
            step("R5", 0, 1, 1'((32'h00B1D3 >> i) & 1), i[0], 8'($urandom), ~i[0], 0, 0, '0);
        // R6 capture after scan
        step("R6", 0, 0, 0, 1, 8'h96, 1, 0, 0, '0);
        step("R6", 0, 0, 0, 0, 8'h00, 0, 0, 0, '0);
        // R7 valid unlock
        step("R7", 0, 0, 0, 0, '0, 0, 1, 0, 8'hA5);
        step("R7", 0, 0, 0, 0, '0, 0, 0, 0, '0);
        // R9 lock held unlocked through scan with relock requests
        for (int i = 0; i < 20; i++)
            step("R9", 0, 1, 1'($urandom), 0, '0, 0, i[0], ~i[0], 8'hA5);
        // R10 relock, and priority over unlock
        step("R10", 0, 0, 0, 0, '0, 0, 0, 1, '0);
        step("R10", 0, 0, 0, 0, '0, 0, 1, 1, 8'hA5);
        step("R7", 0, 0, 0, 0, '0, 0, 1, 0, 8'hA5);
        step("R10", 0, 0, 0, 0, '0, 0, 1, 1, 8'hA5);
        // R9 locked state through long scan
        for (int i = 0; i < 30; i++)
            step("R9", 0, 1, 1'($urandom), 0, '0, 0, 1, 0, 8'hA5);
        // R1 reset from busy state
        step("R1", 1, 0, 0, 0, '0, 0, 0, 0, '0);
        step("R1", 0, 0, 0, 0, '0, 0, 0, 0, '0);
        @(posedge clk); #3;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule